// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block is combinational. It moves a 16-bit accumulator value by one bit position, to the left or to the right. An 8-bit operation code selects one of eight variants. The variants fall into four groups: plain shifts, shifts that take in the carry, plain rotates, and rotates through the carry. Each group has a left form and a right form.

The caller supplies the operand and the current carry flag, and writes the result back to the same register. The new zero, negative and carry flags come out of the block at the same time as the result. A valid output is high only for the eight operation codes the block owns. This lets a wider execute stage merge the unit's outputs with the outputs of other units.

The block holds no state. Multi-bit shift counts, the register file and flag storage are kept outside it.

Top module: `shift_rotate_unit`

## Requirements
- R1: `valid` is 1 exactly when `opcode` is in the range 0x46 to 0x4D. The codes map as follows: 0x46 shift left, 0x47 shift right, 0x48 shift left with carry-in, 0x49 shift right with carry-in, 0x4A rotate left, 0x4B rotate right, 0x4C rotate left through carry, 0x4D rotate right through carry.
- R2: For any other opcode, `result`, `zeroFlag`, `negFlag` and `carryOut` are all 0.
- R3: Shift left (0x46) and shift right (0x47) move the operand by one bit and fill the vacated end with 0. `carryOut` takes the bit shifted out: bit 15 for a left shift, bit 0 for a right shift.
- R4: Shift left with carry-in (0x48) and shift right with carry-in (0x49) fill the vacated end with `carryIn`. `carryOut` takes the bit shifted out.
- R5: Rotate left (0x4A) and rotate right (0x4B) put the bit leaving one end into the other end. `carryOut` takes a copy of that bit.
- R6: Rotate left through carry (0x4C) and rotate right through carry (0x4D) treat the operand and the carry as one 17-bit ring. The old carry enters the vacated end, and the bit leaving goes to `carryOut`.
- R7: For a valid opcode, `zeroFlag` is 1 exactly when `result` is zero.
- R8: For a valid opcode, `negFlag` equals `result[15]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Operation code |
| operand | input | 16 | Accumulator value to move |
| carryIn | input | 1 | Current carry flag |
| result | output | 16 | Moved value, zero when not valid |
| zeroFlag | output | 1 | New zero flag |
| negFlag | output | 1 | New negative flag |
| carryOut | output | 1 | New carry flag |
| valid | output | 1 | Opcode belongs to this unit |

## Verification
The checks assume that all three inputs are stable, known values whenever they are evaluated. They also assume that the outputs have settled before anything reads them, since the block has no register to line the two up. The bench changes all inputs together half a period before each sample and reads the outputs two nanoseconds later. It drives only two-state values.

The operand sweep uses a stride that reaches both ends of the range. Directed vectors then cover the all-zero, all-one and single-bit operands, where the carry and the zero flag interact.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  localparam int unsigned OPC_W        = 8;
  localparam logic [OPC_W-1:0] OPC_FIRST = 8'h46;
  localparam int unsigned NUM_VARIANTS = 8;
  localparam int unsigned SEL_W        = $clog2(NUM_VARIANTS);

  // Offset bit 0 picks the direction, bit 1 the carry fill, bit 2 rotation.
  typedef struct packed {
    logic valid;
    logic toRight;
    logic useCarry;
    logic circular;
  } shiftCtrl_t;

endpackage

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
#(
  parameter logic [OPC_W-1:0] BASE = OPC_FIRST
) (
  input  logic [OPC_W-1:0] opcode,
  output shiftCtrl_t       strobes
);

  logic [OPC_W-1:0] offset;
  logic             inRange;

  always_comb begin
    offset  = opcode - BASE;
    inRange = (offset < OPC_W'(NUM_VARIANTS));
    strobes.valid    = inRange;
    strobes.toRight  = inRange & offset[0];
    strobes.useCarry = inRange & offset[1];
    strobes.circular = inRange & offset[2];
  end

endmodule

// File: rtl/shift_rotate_datapath.sv
module shift_rotate_datapath
  import shift_rotate_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  shiftCtrl_t       strobes,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int unsigned MSB = WIDTH - 1;

  logic             exitBit;
  logic             fillBit;
  logic [WIDTH-1:0] moved;

  always_comb begin
    exitBit = strobes.toRight ? operand[0] : operand[MSB];
    if (strobes.useCarry)      fillBit = carryIn;
    else if (strobes.circular) fillBit = exitBit;
    else                       fillBit = 1'b0;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromLeftMove;
    logic fromRightMove;
    if (i == 0) begin : g_low
      assign fromLeftMove = fillBit;
    end else begin : g_lowN
      assign fromLeftMove = operand[i-1];
    end
    if (i == MSB) begin : g_high
      assign fromRightMove = fillBit;
    end else begin : g_highN
      assign fromRightMove = operand[i+1];
    end
    assign moved[i] = strobes.toRight ? fromRightMove : fromLeftMove;
  end

  assign result   = strobes.valid ? moved : '0;
  assign carryOut = strobes.valid & exitBit;

endmodule

// File: rtl/shift_rotate_flags.sv
module shift_rotate_flags #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             enable,
  input  logic [WIDTH-1:0] value,
  output logic             zeroFlag,
  output logic             negFlag
);

  assign zeroFlag = enable & ~(|value);
  assign negFlag  = enable & value[WIDTH-1];

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [7:0]       opcode,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             carryOut,
  output logic             valid
);

  shiftCtrl_t strobes;

  shift_rotate_ctrl #(.BASE(OPC_FIRST)) u_ctrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  shift_rotate_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobes  (strobes),
    .operand  (operand),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut)
  );

  shift_rotate_flags #(.WIDTH(WIDTH)) u_flags (
    .enable   (strobes.valid),
    .value    (result),
    .zeroFlag (zeroFlag),
    .negFlag  (negFlag)
  );

  assign valid = strobes.valid;

endmodule

// File: rtl/shift_rotate_checker.sv
module shift_rotate_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic [7:0]       opcode,
  input logic [WIDTH-1:0] operand,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             negFlag,
  input logic             carryOut,
  input logic             valid
);

  always_comb begin
    assert_valid_range_R1: assert (valid == (opcode >= 8'h46 && opcode <= 8'h4D));
    if (!valid) begin
      assert_idle_zero_R2: assert (result == '0 && !zeroFlag && !negFlag && !carryOut);
    end
    if (opcode == 8'h46) begin
      assert_shl_fill_R3: assert (result[0] == 1'b0 && carryOut == operand[WIDTH-1]);
    end
    if (opcode == 8'h47) begin
      assert_shr_fill_R3: assert (result[WIDTH-1] == 1'b0 && carryOut == operand[0]);
    end
    if (opcode == 8'h48 || opcode == 8'h49) begin
      assert_carry_fill_R4: assert ((opcode == 8'h48 ? result[0] : result[WIDTH-1]) == carryIn);
    end
    if (opcode == 8'h4A || opcode == 8'h4B) begin
      assert_ring_ones_R5: assert ($countones(result) == $countones(operand));
    end
    if (opcode == 8'h4C || opcode == 8'h4D) begin
      assert_ring17_ones_R6: assert (($countones(result) + 32'(carryOut)) ==
                                     ($countones(operand) + 32'(carryIn)));
    end
    if (valid) begin
      assert_zero_flag_R7: assert (zeroFlag == (result == '0));
      assert_neg_flag_R8:  assert (negFlag == result[WIDTH-1]);
    end
  end

endmodule

bind shift_rotate_unit shift_rotate_checker #(.WIDTH(WIDTH)) u_chk (
  .opcode   (opcode),
  .operand  (operand),
  .carryIn  (carryIn),
  .result   (result),
  .zeroFlag (zeroFlag),
  .negFlag  (negFlag),
  .carryOut (carryOut),
  .valid    (valid)
);

// File: tb/sim_shift_rotate_unit.sv
`timescale 1ns/1ps
module sim_shift_rotate_unit;

  logic        clk = 1'b0;
  logic [7:0]  opcode;
  logic [15:0] operand;
  logic        carryIn;
  logic [15:0] result;
  logic        zeroFlag, negFlag, carryOut, valid;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  shift_rotate_unit u0 (
    .opcode(opcode), .operand(operand), .carryIn(carryIn),
    .result(result), .zeroFlag(zeroFlag), .negFlag(negFlag),
    .carryOut(carryOut), .valid(valid)
  );

  function automatic string tagFor(input logic [7:0] op);
    case (op)
      8'h46, 8'h47: return "R3";
      8'h48, 8'h49: return "R4";
      8'h4A, 8'h4B: return "R5";
      8'h4C, 8'h4D: return "R6";
      default:      return "R2";
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [15:0] val, input logic cin);
    logic [15:0] expRes;
    logic        expC, expV, fill;
    @(negedge clk);
    opcode = op; operand = val; carryIn = cin;
    #2;
    expV = (op >= 8'h46 && op <= 8'h4D);
    expRes = '0; expC = 1'b0;
    if (expV) begin
      if (op[0]) expC = val[0]; else expC = val[15];     // bit shifted out
      case (op)
        8'h46, 8'h47: fill = 1'b0;                         // R3
        8'h48, 8'h49, 8'h4C, 8'h4D: fill = cin;           // R4, R6
        default: fill = expC;                             // R5
      endcase
      if (op[0]) expRes = {fill, val[15:1]};
      else       expRes = {val[14:0], fill};
    end
    vectors++;
    if (valid !== expV) begin
      misses++; $display("FAIL R1 op=%02h valid=%b exp=%b", op, valid, expV);
    end
    if (result !== expRes || carryOut !== expC) begin
      misses++;
      $display("FAIL %s op=%02h val=%04h cin=%b res=%04h/c%b exp=%04h/c%b",
               tagFor(op), op, val, cin, result, carryOut, expRes, expC);
    end
    if (zeroFlag !== (expV && expRes == 16'h0)) begin
      misses++; $display("FAIL R7 op=%02h z=%b exp=%b", op, zeroFlag, expV && expRes == 16'h0);
    end
    if (negFlag !== (expV && expRes[15])) begin
      misses++; $display("FAIL R8 op=%02h n=%b exp=%b", op, negFlag, expV && expRes[15]);
    end
  endtask

  initial begin
    opcode = 8'h00; operand = 16'h0; carryIn = 1'b0;
    // R2: idle state with an unowned code
    apply(8'h00, 16'h0000, 1'b0);
    // R3 R4 R5 R6 R7 R8: directed corners on every variant
    for (int op = 8'h46; op <= 8'h4D; op++) begin
      for (int c = 0; c < 2; c++) begin
        apply(8'(op), 16'h0000, 1'(c));
        apply(8'(op), 16'hFFFF, 1'(c));
        apply(8'(op), 16'h8000, 1'(c));
        apply(8'(op), 16'h0001, 1'(c));
        apply(8'(op), 16'h4000, 1'(c));
        apply(8'(op), 16'h0002, 1'(c));
      end
    end
    // R1 R2: every opcode against a few operands
    for (int op = 0; op < 256; op++) begin
      apply(8'(op), 16'hFFFF, 1'b1);
      apply(8'(op), 16'h8001, 1'b0);
    end
    // Strided operand sweep on the owned codes
    for (int op = 8'h46; op <= 8'h4D; op++) begin
      for (int v = 0; v < 65536; v += 37) begin
        apply(8'(op), 16'(v), 1'b0);
        apply(8'(op), 16'(v ^ 16'hFFFF), 1'b1);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule